// File: doc/BRIEF.md
# Stereo Attenuation Control Port

This block receives control words from a host over three slow wires: a bit clock, a data line and a latch strobe. Each 16-bit word arrives most significant bit first. When the latch strobe rises, the word is written into one of four program registers. Two bits in the word pick the register. All three wires are synchronized into the system clock domain. Edges of the bit clock and of the strobe are detected there, so the whole block runs on the system clock.

Two of the registers hold attenuation steps for the left and right channels. A written step first goes into a pending copy. It reaches the active gain path only when a word carries its load flag. That flag, in either channel's word, moves both pending steps into the active registers in the same cycle, so the two channels change level together. The other two registers hold mode and format fields. These are presented as parallel outputs for the converter logic that reads them.

The active 8-bit step is turned into a 9-bit linear gain. Steps 0 to 254 map to themselves, and step 255 maps to 256, which is exact unity. Each 16-bit signed stereo sample is multiplied by this gain, and the product is shifted right by 8. The result is registered one cycle after the sample.

Top module: `att_ctl_port`

## Requirements
- R1: After reset, the pending and active steps of both channels are 255, so the outputs equal the inputs. Both mode_o and fmt_o read 0.
- R2: The data line is sampled on each rising edge of ctl_sck, most significant bit first. A rising edge of ctl_lat commits the word only if exactly 16 bits arrived since the previous rising edge of ctl_lat. After 15 or 17 bits the word is discarded and no register changes.
- R3: Word bits 10:9 select the register: 0 is the left step, 1 is the right step, 2 is mode and 3 is format. Bits 15:11 have no effect.
- R4: A word to register 0 or 1 with bit 8 clear stores bits 7:0 as that channel's pending step only. The active steps of both channels, and so the output levels, keep their previous values.
- R5: A word to register 0 or 1 with bit 8 set first stores its step. In the same cycle it then copies both pending steps into both active steps.
- R6: Each output sample is floor(x_in * g / 256), where g is the active step for steps 0 to 254 and g is 256 for step 255. The output appears one clock after the input sample.
- R7: Active step 0 gives an output of exactly zero. Active step 255 gives an output exactly equal to the input.
- R8: A word to register 2 copies bits 8:0 to mode_o. Bit 0 is mute, bit 1 is de-emphasis enable, bit 2 is operation enable, bits 4:3 are input word width and bits 8:5 are output mode.
- R9: A word to register 3 sets fmt_o as follows. Bit 0 is data format select, bit 1 is LR clock polarity, bit 2 is attenuator control, bits 7:6 are sample rate and bit 8 is zero-detect enable. Bits 5:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_sck | input | 1 | Serial bit clock, asynchronous |
| ctl_sdi | input | 1 | Serial data, asynchronous |
| ctl_lat | input | 1 | Latch strobe, asynchronous |
| smp_l_i | input | 16 | Left input sample, signed |
| smp_r_i | input | 16 | Right input sample, signed |
| smp_l_o | output | 16 | Left attenuated sample, signed |
| smp_r_o | output | 16 | Right attenuated sample, signed |
| mode_o | output | 9 | Mode register fields |
| fmt_o | output | 9 | Format register fields |

## Verification
On every cycle, the assertions check the following. Active steps stay put unless a committed word with its load flag arrives. A flagged word leaves active equal to pending in both channels, and a left word lands in the pending copy. Step 0 and step 255 give zero and pass-through output on the next cycle. Only the bench's scenarios can show the rest. That covers the bit count rule for 15 or 17 bits, MSB-first assembly through the synchronizers, and that reserved bits are ignored. It also covers the exact rounding of the gain for arbitrary steps and samples, and the mode and format field positions seen from the ports.

// File: rtl/att_ctl_pkg.sv
// Package: shared register selector encoding and field masks for the
// attenuation control port. Assumes a 16-bit control word whose bits 10:9
// carry the register selector.
package att_ctl_pkg;

    typedef enum logic [1:0] {
        SEL_STEP_L = 2'd0,
        SEL_STEP_R = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_FMT    = 2'd3
    } reg_sel_e;

    // Format register keeps bits 8:6 and 2:0; bits 5:3 are reserved.
    localparam logic [8:0] FMT_MASK = 9'b111_000_111;

endpackage

// File: rtl/att_serial_rx.sv
// Serial receiver: synchronizes bit clock, data and latch into clk, shifts
// bits MSB first on each bit clock rising edge and raises word_vld for one
// cycle when the latch strobe rises after exactly WORD_W bits.
// Assumes each serial level is held for several clk cycles. Only the low
// PAY_W bits of the word are kept; older bits fall off the shift register.
module att_serial_rx #(
    parameter int WORD_W = 16,
    parameter int PAY_W  = 11,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             sdi,
    input  logic             lat,
    output logic             word_vld,
    output logic [PAY_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    logic [SYNC_N:0]   sck_q;
    logic [SYNC_N:0]   lat_q;
    logic [SYNC_N-1:0] sdi_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sck_rise;
    logic              lat_rise;

    // Synchronizer chains, with one extra stage on the edge-detected lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= '0;
            lat_q <= '0;
            sdi_q <= '0;
        end else begin
            sck_q <= {sck_q[SYNC_N-1:0], sck};
            lat_q <= {lat_q[SYNC_N-1:0], lat};
            sdi_q <= {sdi_q[SYNC_N-2:0], sdi};
        end
    end

    assign sck_rise = sck_q[SYNC_N-1] & ~sck_q[SYNC_N];
    assign lat_rise = lat_q[SYNC_N-1] & ~lat_q[SYNC_N];
    assign word_vld = lat_rise && (bit_cnt == CNT_FULL);

    // Shift in bits and count them; a latch edge restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (lat_rise) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            word <= {word[PAY_W-2:0], sdi_q[SYNC_N-1]};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/att_reg_bank.sv
// Register bank: decodes committed words into pending steps, active steps
// and the mode and format registers. A load flag in a left or right step
// word copies both pending steps to the active ones in the same cycle.
// Assumes word_vld is a single-cycle pulse.
module att_reg_bank
    import att_ctl_pkg::*;
#(
    parameter int STEP_W = 8,
    parameter int PAY_W  = 11,
    parameter int FLD_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [PAY_W-1:0]  word,
    output logic [STEP_W-1:0] pend_l,
    output logic [STEP_W-1:0] pend_r,
    output logic [STEP_W-1:0] act_l,
    output logic [STEP_W-1:0] act_r,
    output logic [FLD_W-1:0]  mode_q,
    output logic [FLD_W-1:0]  fmt_q
);
    localparam logic [STEP_W-1:0] STEP_UNITY = '1;

    reg_sel_e          sel;
    logic              ld_flag;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] pend_l_nx;
    logic [STEP_W-1:0] pend_r_nx;

    assign sel     = reg_sel_e'(word[PAY_W-1:PAY_W-2]);
    assign ld_flag = word[STEP_W];
    assign step    = word[STEP_W-1:0];

    // Next pending values, so a flagged word commits its own step too.
    always_comb begin
        pend_l_nx = pend_l;
        pend_r_nx = pend_r;
        if (word_vld && sel == SEL_STEP_L) pend_l_nx = step;
        if (word_vld && sel == SEL_STEP_R) pend_r_nx = step;
    end

    // Pending and active step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l <= STEP_UNITY;
            pend_r <= STEP_UNITY;
            act_l  <= STEP_UNITY;
            act_r  <= STEP_UNITY;
        end else begin
            pend_l <= pend_l_nx;
            pend_r <= pend_r_nx;
            if (word_vld && ld_flag &&
                (sel == SEL_STEP_L || sel == SEL_STEP_R)) begin
                act_l <= pend_l_nx;
                act_r <= pend_r_nx;
            end
        end
    end

    // Mode and format registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            fmt_q  <= '0;
        end else if (word_vld) begin
            if (sel == SEL_MODE) mode_q <= word[FLD_W-1:0];
            if (sel == SEL_FMT)  fmt_q  <= word[FLD_W-1:0] & FMT_MASK;
        end
    end
endmodule

// File: rtl/att_gain_mul.sv
// Gain stage: maps a step to a linear gain (step, or 2**STEP_W at the top
// code) and registers floor(sample * gain / 2**STEP_W). Assumes the gain
// never exceeds 2**STEP_W, so the result fits the sample width.
module att_gain_mul #(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [STEP_W-1:0]          step,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    output logic signed [SAMPLE_W-1:0] smp_o
);
    localparam int GAIN_W = STEP_W + 1;
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

    logic [GAIN_W-1:0]        gain;
    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] prod;

    // Step to gain mapping with the jump to exact unity at the top code.
    always_comb begin
        gain  = (step == '1) ? GAIN_W'(1 << STEP_W) : {1'b0, step};
        s_ext = {{(PROD_W-SAMPLE_W){smp_i[SAMPLE_W-1]}}, smp_i};
        g_ext = {{(PROD_W-GAIN_W){1'b0}}, gain};
        prod  = s_ext * g_ext;
    end

    // Output register with a floor shift.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_o <= '0;
        else        smp_o <= SAMPLE_W'(prod >>> STEP_W);
    end
endmodule

// File: rtl/att_ctl_port.sv
// Top: serial control port with staged stereo attenuation. Joins the
// receiver, the register bank and one gain stage per channel.
// Assumes serial wires change slowly compared with clk.
module att_ctl_port #(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 8,
    parameter int WORD_W   = 16,
    parameter int SYNC_N   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_sck,
    input  logic                       ctl_sdi,
    input  logic                       ctl_lat,
    input  logic signed [SAMPLE_W-1:0] smp_l_i,
    input  logic signed [SAMPLE_W-1:0] smp_r_i,
    output logic signed [SAMPLE_W-1:0] smp_l_o,
    output logic signed [SAMPLE_W-1:0] smp_r_o,
    output logic [STEP_W:0]            mode_o,
    output logic [STEP_W:0]            fmt_o
);
    localparam int FLD_W = STEP_W + 1;
    localparam int PAY_W = FLD_W + 2;
    localparam int N_CH  = 2;

    logic              word_vld;
    logic [PAY_W-1:0]  word;
    logic [STEP_W-1:0] pend_l, pend_r, act_l, act_r;

    logic [STEP_W-1:0]          ch_step [N_CH];
    logic signed [SAMPLE_W-1:0] ch_in   [N_CH];
    logic signed [SAMPLE_W-1:0] ch_out  [N_CH];

    att_serial_rx #(.WORD_W(WORD_W), .PAY_W(PAY_W), .SYNC_N(SYNC_N)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck(ctl_sck), .sdi(ctl_sdi), .lat(ctl_lat),
        .word_vld(word_vld), .word(word)
    );

    att_reg_bank #(.STEP_W(STEP_W), .PAY_W(PAY_W), .FLD_W(FLD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .pend_l(pend_l), .pend_r(pend_r), .act_l(act_l), .act_r(act_r),
        .mode_q(mode_o), .fmt_q(fmt_o)
    );

    assign ch_step[0] = act_l;
    assign ch_step[1] = act_r;
    assign ch_in[0]   = smp_l_i;
    assign ch_in[1]   = smp_r_i;
    assign smp_l_o    = ch_out[0];
    assign smp_r_o    = ch_out[1];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        att_gain_mul #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W)) u_gain (
            .clk(clk), .rst_n(rst_n), .step(ch_step[c]),
            .smp_i(ch_in[c]), .smp_o(ch_out[c])
        );
    end
endmodule

// File: rtl/att_ctl_port_chk.sv
// Checker: cycle-level properties of staging and of the gain extremes,
// bound into every instance of the top module.
module att_ctl_port_chk #(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 8,
    parameter int PAY_W    = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                word_vld,
    input logic [PAY_W-1:0]    word,
    input logic [STEP_W-1:0]   pend_l,
    input logic [STEP_W-1:0]   pend_r,
    input logic [STEP_W-1:0]   act_l,
    input logic [STEP_W-1:0]   act_r,
    input logic [SAMPLE_W-1:0] smp_l_i,
    input logic [SAMPLE_W-1:0] smp_l_o
);
    AST_ACT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(act_l) && $stable(act_r)); // R4

    AST_ACT_NOFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && !word[PAY_W-1] && !word[STEP_W] |=> $stable(act_l) && $stable(act_r)); // R4

    AST_FLAG_COMMITS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && !word[PAY_W-1] && word[STEP_W] |=> act_l == pend_l && act_r == pend_r); // R5

    AST_LEFT_PEND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && word[PAY_W-1:PAY_W-2] == 2'd0 |=> pend_l == $past(word[STEP_W-1:0])); // R3

    AST_STEP0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        act_l == '0 |=> smp_l_o == '0); // R7

    AST_TOP_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        act_l == '1 |=> smp_l_o == $past(smp_l_i)); // R7
endmodule

bind att_ctl_port att_ctl_port_chk #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W), .PAY_W(PAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
    .pend_l(pend_l), .pend_r(pend_r), .act_l(act_l), .act_r(act_r),
    .smp_l_i(smp_l_i), .smp_l_o(smp_l_o)
);

// File: tb/att_ctl_port_tb.sv
module att_ctl_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic sck = 0, sdi = 0, lat = 0;
    logic signed [15:0] sl_i = 0, sr_i = 0;
    logic signed [15:0] sl_o, sr_o;
    logic [8:0] mode_o, fmt_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_pl = 8'hFF, m_pr = 8'hFF, m_al = 8'hFF, m_ar = 8'hFF;
    logic [8:0] m_mode = 0, m_fmt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    att_ctl_port u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_sck(sck), .ctl_sdi(sdi), .ctl_lat(lat),
        .smp_l_i(sl_i), .smp_r_i(sr_i), .smp_l_o(sl_o), .smp_r_o(sr_o),
        .mode_o(mode_o), .fmt_o(fmt_o)
    );

    function automatic int exp_gain(input logic signed [15:0] s, input logic [7:0] st);
        int y;
        int p;
        y = (st == 8'hFF) ? 256 : int'(st);
        p = int'(s) * y;
        return p >>> 8;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_commit(input logic [15:0] w);
        case (w[10:9])
            2'd0: begin m_pl = w[7:0]; if (w[8]) begin m_al = m_pl; m_ar = m_pr; end end
            2'd1: begin m_pr = w[7:0]; if (w[8]) begin m_al = m_pl; m_ar = m_pr; end end
            2'd2: m_mode = w[8:0];
            default: m_fmt = w[8:0] & 9'h1C7;
        endcase
    endtask

    task automatic send(input logic [31:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = w[i];
            repeat (HALF_BIT) @(negedge clk);
            sck = 1;
            repeat (HALF_BIT) @(negedge clk);
            sck = 0;
        end
        repeat (HALF_BIT) @(negedge clk);
        lat = 1;
        repeat (HALF_BIT) @(negedge clk);
        lat = 0;
        repeat (HALF_BIT + 2) @(negedge clk);
        if (nbits == 16) model_commit(w[15:0]);
    endtask

    task automatic check_all(input string tag, input logic signed [15:0] a, input logic signed [15:0] b);
        @(negedge clk);
        sl_i = a;
        sr_i = b;
        repeat (2) @(negedge clk);
        chk({tag, " left"},  int'(sl_o), exp_gain(a, m_al));
        chk({tag, " right"}, int'(sr_o), exp_gain(b, m_ar));
        chk({tag, " mode"},  int'(mode_o), int'(m_mode));
        chk({tag, " fmt"},   int'(fmt_o), int'(m_fmt));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7541));
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state, unity pass-through and cleared fields
        check_all("R1 reset", 16'sd12345, -16'sd20000);
        chk("R1 mode zero", int'(mode_o), 0);
        // R4: left step 0 stored without flag, outputs unchanged
        send({16'b0, 5'b0, 2'd0, 1'b0, 8'd0}, 16);
        check_all("R4 staged", 16'sd1000, 16'sd1000);
        // R5 R7: flagged right word commits both channels
        send({16'b0, 5'b0, 2'd1, 1'b1, 8'd128}, 16);
        check_all("R5 R7 commit", 16'sd1000, -16'sd1001);
        chk("R7 silence", int'(sl_o), 0);
        // R2: 15-bit and 17-bit words are discarded
        send({16'b0, 5'b0, 2'd1, 1'b1, 8'd255}, 15);
        check_all("R2 short", 16'sd500, 16'sd500);
        send({15'b0, 1'b1, 5'b0, 2'd1, 1'b1, 8'd255}, 17);
        check_all("R2 long", 16'sd500, 16'sd500);
        // R3: reserved high bits ignored
        send({16'b0, 5'b11111, 2'd0, 1'b1, 8'd254}, 16);
        check_all("R3 reserved", 16'sd32767, -16'sd32768);
        // R6: floor rounding at small steps and negative samples
        send({16'b0, 5'b0, 2'd1, 1'b1, 8'd1}, 16);
        check_all("R6 floor", -16'sd1, -16'sd32768);
        // R8 R9: mode and format field positions
        send({16'b0, 5'b0, 2'd2, 9'b1010_11_1_0_1}, 16);
        send({16'b0, 5'b0, 2'd3, 9'b1_01_111_0_1_1}, 16);
        check_all("R8 R9 fields", 16'sd7, 16'sd7);
        chk("R9 reserved zero", int'(fmt_o[5:3]), 0);
        // R7: top code is exact unity
        send({16'b0, 5'b0, 2'd0, 1'b1, 8'd255}, 16);
        check_all("R7 unity", -16'sd32768, 16'sd32767);
        // Random words and samples, R2 R3 R4 R5 R6 R8 R9
        for (int n = 0; n < 40; n++) begin
            logic [31:0] w;
            int nb;
            w  = $urandom;
            nb = ($urandom_range(0, 7) == 0) ? (15 + 2 * $urandom_range(0, 1)) : 16;
            send(w, nb);
            check_all("R6 random", 16'($urandom), 16'($urandom));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule